// File: doc/BRIEF.md
# Auto-Reloading Single-Channel DMA Sequencer

This block is one DMA channel that copies a byte or a 16-bit word each time a transfer request arrives. One side of every copy is a 24-bit memory pointer that steps up or down after each transfer. The other side is a fixed I/O location in the top 64 KiB page of the address space. A direction bit picks which side is read and which side is written.

Software loads the pointer, the I/O location, a transfer counter with its reload value, and a control word. After that the channel runs with no further software action. When the counter runs out, the counter and the pointer both return to their programmed start values, and the next request begins a new run.

Each transfer takes one read cycle on a single-cycle bus master port, then one write cycle. A done strobe marks the write cycle. Requests that arrive while a transfer is in progress are counted and served one after another.

Top module: `dma_rpt_chan`

## Requirements
- R1: After reset the bus port is idle (`bus_valid`=0), `xfer_done`=0, and `cur_mar` and `cur_count` read 0.
- R2: The channel is active only when control bit 0 (channel enable) is 1, control bit 1 (repeat enable) is 1 and control bit 2 (end-interrupt enable) is 0. While it is inactive, requests cause no bus cycle and the pointer and counter do not change.
- R3: A transfer is one read cycle at the source address, followed on the next cycle by one write cycle at the destination address. The write carries the read data: all 16 bits for a word, or the low byte with the upper byte zero for a byte. `xfer_done` is high during the write cycle.
- R4: With control bit 3 = 0 the memory pointer is the source and the I/O location is the destination. With control bit 3 = 1 the roles swap.
- R5: The I/O side address is {0xFF, io_lo[15:0]}. It never changes during operation.
- R6: After each transfer the pointer moves by 1 (byte, control bit 4 = 0) or by 2 (word, control bit 4 = 1). It moves up when control bit 5 = 0 and down when bit 5 = 1. It holds when no transfer completes and no write targets it.
- R7: For word transfers, bus address bit 0 is 0 on both the memory side and the I/O side.
- R8: The counter decrements on each transfer. When it reaches 0 it is loaded from the reload value, and the pointer is restored to the value last written to it.
- R9: A counter or reload value of 0 gives 256 transfers per run.
- R10: Each accepted request produces exactly one transfer. Requests made in consecutive cycles are all served, in order.
- R11: Clearing channel enable stops the channel after the transfer in progress, and drops any pending requests. The pointer and counter keep their values.
- R12: Register writes use `cfg_sel`: 0 writes the pointer, 1 writes io_lo from `cfg_wdata[15:0]`, 2 writes the counter from `[7:0]` and the reload value from `[15:8]`, and 3 writes control from `[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| xfer_req | input | 1 | Transfer request, one per cycle high |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |
| xfer_done | output | 1 | High during the write cycle of each transfer |
| cur_mar | output | 24 | Current memory pointer |
| cur_count | output | 8 | Current transfer counter |

## Verification
The assertions check on every cycle that:
- a read cycle is always followed by a write cycle, and the done strobe only appears on a write;
- word addresses are even, and the I/O side sits in the top page;
- the counter either steps down by one or reloads at the end of a run;
- the pointer stays still unless a transfer completes or a register write reaches it.

Only the bench scenarios can show that the addresses and the copied data are correct, and that the pointer returns to its start after a run. They also cover the 256-transfer run, the direction swap, queued back-to-back requests, and the fact that requests made while inactive or before a disable leave no trace.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  // control word, bit 0 = ch_en ... bit 5 = dec
  typedef struct packed {
    logic dec;
    logic word;
    logic dir;
    logic end_ie;
    logic rpt_en;
    logic ch_en;
  } chan_ctrl_t;

  localparam logic [1:0] SEL_MAR  = 2'd0;
  localparam logic [1:0] SEL_IO   = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/dma_rpt_regs.sv
module dma_rpt_regs
  import dma_rpt_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          commit,
  output logic [AW-1:0] mar_q,
  output logic [IOW-1:0] io_q,
  output logic [CW-1:0] cnt_q,
  output chan_ctrl_t    ctrl_q
);

  localparam int CTRL_W = $bits(chan_ctrl_t);

  logic [AW-1:0]  mar_d, start_q, start_d, step;
  logic [IOW-1:0] io_d;
  logic [CW-1:0]  cnt_d, rel_q, rel_d, cnt_dec;
  chan_ctrl_t     ctrl_d;

  always_comb begin
    mar_d   = mar_q;
    start_d = start_q;
    io_d    = io_q;
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    ctrl_d  = ctrl_q;
    step    = ctrl_q.word ? AW'(2) : AW'(1);
    cnt_dec = cnt_q - CW'(1);
    if (commit) begin
      if (cnt_dec == '0) begin
        cnt_d = rel_q;
        mar_d = start_q;
      end else begin
        cnt_d = cnt_dec;
        mar_d = ctrl_q.dec ? (mar_q - step) : (mar_q + step);
      end
    end
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_MAR: begin
          mar_d   = cfg_wdata;
          start_d = cfg_wdata;
        end
        SEL_IO:  io_d = cfg_wdata[IOW-1:0];
        SEL_CNT: begin
          cnt_d = cfg_wdata[CW-1:0];
          rel_d = cfg_wdata[2*CW-1:CW];
        end
        default: ctrl_d = chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q   <= '0;
      start_q <= '0;
      io_q    <= '0;
      cnt_q   <= '0;
      rel_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      mar_q   <= mar_d;
      start_q <= start_d;
      io_q    <= io_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
      ctrl_q  <= ctrl_d;
    end
  end

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cfg_we) |=> ((cnt_q == $past(cnt_q) - CW'(1)) ||
                             ($past(cnt_q) == CW'(1) && cnt_q == $past(rel_q))));

  // R6
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !cfg_we) |=> $stable(mar_q));

endmodule

// File: rtl/dma_rpt_seq.sv
module dma_rpt_seq
  import dma_rpt_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic xfer_req,
  output logic st_rd,
  output logic st_wr
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  seq_state_e       st_q, st_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic             req_acc, commit;

  assign commit  = (st_q == ST_WR);
  assign req_acc = xfer_req && active && (pend_q != PEND_MAX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (active && pend_q != '0) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (req_acc && !commit)      pend_d = pend_q + PEND_W'(1);
    else if (!req_acc && commit) pend_d = pend_q - PEND_W'(1);
    if (st_q == ST_IDLE && !active) pend_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign st_rd = (st_q == ST_RD);
  assign st_wr = commit;

  // R10
  pend_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR) |-> (pend_q != '0));

endmodule

// File: rtl/dma_rpt_bus.sv
module dma_rpt_bus
  import dma_rpt_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_rd,
  input  logic           st_wr,
  input  logic           dir,
  input  logic           word,
  input  logic [AW-1:0]  mar,
  input  logic [IOW-1:0] io_lo,
  input  logic [DW-1:0]  rdata,
  output logic           bus_valid,
  output logic           bus_write,
  output logic           bus_word,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata
);

  localparam int PAGE_W = AW - IOW;

  logic [AW-1:0] mem_a, io_a, src_a, dst_a;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  assign mem_a = word ? {mar[AW-1:1], 1'b0} : mar;
  assign io_a  = word ? {{PAGE_W{1'b1}}, io_lo[IOW-1:1], 1'b0}
                      : {{PAGE_W{1'b1}}, io_lo};
  assign src_a = dir ? io_a : mem_a;
  assign dst_a = dir ? mem_a : io_a;

  assign data_en = st_rd;
  assign data_d  = word ? rdata : {{(DW-8){1'b0}}, rdata[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign bus_valid = st_rd | st_wr;
  assign bus_write = st_wr;
  assign bus_word  = word;
  assign bus_addr  = st_wr ? dst_a : src_a;
  assign bus_wdata = data_q;

  // R7
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_word) |-> (bus_addr[0] == 1'b0));

  // R5
  io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_write ^ dir)) |-> (&bus_addr[AW-1:IOW]));

endmodule

// File: rtl/dma_rpt_chan.sv
module dma_rpt_chan
  import dma_rpt_pkg::*;
#(
  parameter int AW     = 24,
  parameter int IOW    = 16,
  parameter int CW     = 8,
  parameter int DW     = 16,
  parameter int PEND_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          xfer_req,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_done,
  output logic [AW-1:0] cur_mar,
  output logic [CW-1:0] cur_count
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           st_rd, st_wr, active;
  logic [IOW-1:0] io_q;
  chan_ctrl_t     ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign active = ctrl_q.ch_en & ctrl_q.rpt_en & ~ctrl_q.end_ie;

  dma_rpt_regs #(.AW(AW), .IOW(IOW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .commit(st_wr),
    .mar_q(cur_mar), .io_q(io_q), .cnt_q(cur_count), .ctrl_q(ctrl_q)
  );

  dma_rpt_seq #(.PEND_W(PEND_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .active(active), .xfer_req(xfer_req),
    .st_rd(st_rd), .st_wr(st_wr)
  );

  dma_rpt_bus #(.AW(AW), .IOW(IOW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_int_n),
    .st_rd(st_rd), .st_wr(st_wr),
    .dir(ctrl_q.dir), .word(ctrl_q.word),
    .mar(cur_mar), .io_lo(io_q), .rdata(bus_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  assign xfer_done = st_wr;

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_valid && !bus_write) |=> (bus_valid && bus_write));

  // R3
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer_done |-> (bus_valid && bus_write));

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!active && !bus_valid) |=> !bus_valid);

endmodule

// File: tb/dma_rpt_chan_bench.sv
module dma_rpt_chan_bench;

  typedef struct {
    bit          wr;
    logic [23:0] a;
    logic [15:0] d;
  } bus_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [23:0] cfg_wdata;
  logic        xfer_req;
  logic        bus_valid, bus_write, bus_word, xfer_done;
  logic [23:0] bus_addr, cur_mar;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  cur_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bus_item_t exp_q[$];

  logic [23:0] m_mar, m_start;
  logic [15:0] m_io;
  logic [7:0]  m_cnt, m_rel;
  logic [5:0]  m_ctrl;

  always #10 clk = ~clk;

  assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;

  dma_rpt_chan u_dma_rpt_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
    .cur_mar(cur_mar), .cur_count(cur_count)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 R10 R11 unexpected bus cycle", {8'h0, bus_addr}, 32'h0);
      end else begin
        bus_item_t e;
        e = exp_q.pop_front();
        chk(bus_write == e.wr, "R3 cycle kind", 32'(bus_write), 32'(e.wr));
        chk(bus_addr == e.a, "R4 R5 R7 address", {8'h0, bus_addr}, {8'h0, e.a});
        if (e.wr) begin
          chk(bus_wdata == e.d, "R3 write data", {16'h0, bus_wdata}, {16'h0, e.d});
          chk(xfer_done == 1'b1, "R3 done strobe", 32'(xfer_done), 32'h1);
        end
      end
    end
  end

  task automatic cfg_write(logic [1:0] sel, logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: begin m_mar = d; m_start = d; end
      2'd1: m_io = d[15:0];
      2'd2: begin m_cnt = d[7:0]; m_rel = d[15:8]; end
      default: m_ctrl = d[5:0];
    endcase
  endtask

  // driver: push the expected read and write of one transfer, update model
  task automatic push_xfer();
    bus_item_t r, w;
    logic [23:0] mem_a, io_a, src, dst;
    logic [15:0] rd;
    logic [7:0]  nc;
    bit word, dir, dec;
    word = m_ctrl[4]; dir = m_ctrl[3]; dec = m_ctrl[5];
    mem_a = word ? {m_mar[23:1], 1'b0} : m_mar;
    io_a  = word ? {8'hFF, m_io[15:1], 1'b0} : {8'hFF, m_io};
    src = dir ? io_a : mem_a;
    dst = dir ? mem_a : io_a;
    rd  = src[15:0] ^ 16'h5A3C;
    r.wr = 0; r.a = src; r.d = 16'h0;
    w.wr = 1; w.a = dst; w.d = word ? rd : {8'h00, rd[7:0]};
    exp_q.push_back(r);
    exp_q.push_back(w);
    nc = m_cnt - 8'd1;
    if (nc == 8'd0) begin
      m_cnt = m_rel; m_mar = m_start;
    end else begin
      m_cnt = nc;
      m_mar = dec ? m_mar - (word ? 24'd2 : 24'd1) : m_mar + (word ? 24'd2 : 24'd1);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 200) begin
      @(negedge clk); t++;
    end
    if (exp_q.size() != 0) begin
      chk(0, "R10 transfer never happened", exp_q.size(), 0);
      exp_q.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_state(string tag);
    chk(cur_mar == m_mar, tag, {8'h0, cur_mar}, {8'h0, m_mar});
    chk(cur_count == m_cnt, tag, {24'h0, cur_count}, {24'h0, m_cnt});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 24'h0; xfer_req = 1'b0;
    m_mar = 0; m_start = 0; m_io = 0; m_cnt = 0; m_rel = 0; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(bus_valid == 1'b0, "R1 bus idle", 32'(bus_valid), 0);
    chk(xfer_done == 1'b0, "R1 done low", 32'(xfer_done), 0);
    chk_state("R1 reset registers");

    // R12 R4 R6 R8: byte, increment, memory is source, wrap after 3
    cfg_write(2'd0, 24'h001000);
    cfg_write(2'd1, 24'h002040);
    cfg_write(2'd2, 24'h000303);
    cfg_write(2'd3, 24'h000003);
    for (int i = 0; i < 3; i++) begin
      push_xfer(); pulse_req(); drain();
      chk_state("R6 R8 byte increment step");
    end
    chk(cur_mar == 24'h001000, "R8 pointer restored", {8'h0, cur_mar}, 32'h001000);
    chk(cur_count == 8'd3, "R8 counter reloaded", {24'h0, cur_count}, 3);
    push_xfer(); pulse_req(); drain();
    chk_state("R8 new run continues");

    // R4 R7 R6: word, decrement, I/O is source, odd addresses forced even
    cfg_write(2'd0, 24'h000205);
    cfg_write(2'd1, 24'h001235);
    cfg_write(2'd2, 24'h000202);
    cfg_write(2'd3, 24'h00003B);
    push_xfer(); pulse_req(); drain();
    chk(cur_mar == 24'h000203, "R6 word decrement", {8'h0, cur_mar}, 32'h000203);
    push_xfer(); pulse_req(); drain();
    chk(cur_mar == 24'h000205, "R8 word restore", {8'h0, cur_mar}, 32'h000205);
    chk_state("R7 word run");

    // R2 inactive: end-interrupt enable set, then repeat enable clear
    cfg_write(2'd3, 24'h000007);
    pulse_req(); repeat (8) @(negedge clk);
    chk_state("R2 end-ie set ignores request");
    cfg_write(2'd3, 24'h000001);
    pulse_req(); repeat (8) @(negedge clk);
    chk_state("R2 repeat off ignores request");

    // R10 back-to-back requests, byte increment across 64K boundary
    cfg_write(2'd0, 24'h00FFFF);
    cfg_write(2'd1, 24'h000010);
    cfg_write(2'd2, 24'h000505);
    cfg_write(2'd3, 24'h000003);
    push_xfer(); push_xfer(); push_xfer();
    @(negedge clk); xfer_req = 1'b1;
    repeat (3) @(negedge clk);
    xfer_req = 1'b0;
    drain();
    chk(cur_mar == 24'h010002, "R10 three queued transfers", {8'h0, cur_mar}, 32'h010002);
    chk(cur_count == 8'd2, "R10 count after queue", {24'h0, cur_count}, 2);

    // R9 zero count means 256 transfers
    cfg_write(2'd0, 24'h300000);
    cfg_write(2'd2, 24'h000000);
    for (int i = 0; i < 255; i++) begin
      push_xfer(); pulse_req(); drain();
    end
    chk(cur_count == 8'd1, "R9 count after 255", {24'h0, cur_count}, 1);
    chk(cur_mar == 24'h3000FF, "R9 pointer after 255", {8'h0, cur_mar}, 32'h3000FF);
    push_xfer(); pulse_req(); drain();
    chk(cur_count == 8'd0, "R9 reload after 256", {24'h0, cur_count}, 0);
    chk(cur_mar == 24'h300000, "R9 restore after 256", {8'h0, cur_mar}, 32'h300000);

    // R11 disable during a transfer: one finishes, pending one dropped
    cfg_write(2'd0, 24'h000400);
    cfg_write(2'd2, 24'h000404);
    push_xfer();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    for (int t = 0; t < 20 && !(bus_valid && !bus_write); t++) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 24'h000002; m_ctrl = 6'h02;
    @(negedge clk); cfg_we = 1'b0;
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R11 in-flight transfer completed", exp_q.size(), 0);
    chk(cur_mar == 24'h000401, "R11 pointer held", {8'h0, cur_mar}, 32'h000401);
    chk(cur_count == 8'd3, "R11 count held", {24'h0, cur_count}, 3);
    cfg_write(2'd3, 24'h000003);
    repeat (12) @(negedge clk);
    chk_state("R11 pending request dropped");

    report();
  end

endmodule